// File: doc/BRIEF.md
# Periodic and Alarm Interrupt Generator

This block sits beside a BCD calendar counter and turns its update strobes and its current time into interrupt requests. A periodic interrupt is raised in the same cycle as the one-second, one-minute, one-hour or one-day strobe that software has picked with a 2-bit rate code. An alarm interrupt is raised when the running time equals a programmed BCD alarm time in all six fields: second, minute, hour, day, month and year. The alarm outcome is held in a status bit until software clears it by writing 1.

A power-off input marks the low-power state. In that state both interrupt lines to the core are held low. A separate wake output still follows the alarm, so an alarm can bring the system back up.

Top module: `rtc_irq_gen`

## Requirements
- R1: After reset all outputs are 0, the control field is 0 (rate 00, both enables off), and the alarm fields hold second 0x00, minute 0x00, hour 0x00, day 0x01, month 0x01, year 0x00.
- R2: With the periodic enable set, `irq_timer_o` is high in exactly the cycles in which the strobe chosen by the rate code is high: 00 picks `sec_tick_i`, 01 picks `min_tick_i`, 10 picks `hour_tick_i`, 11 picks `day_tick_i`.
- R3: With the periodic enable clear, `irq_timer_o` stays low whatever the strobes do.
- R4: A write with `wr_sel_i` 0 to 5 loads `wr_data_i` into the alarm second, minute, hour, day, month or year field, in that order. A write with `wr_sel_i` 6 loads the control field: bits 1:0 are the rate, bit 2 is the periodic enable, bit 3 is the alarm enable.
- R5: `cur_time_i` packs second in bits 7:0, minute in 15:8, hour in 23:16, day in 31:24, month in 39:32 and year in 47:40. When `sec_tick_i` is high and all six fields equal the alarm fields, `alarm_sts_o` is 1 from the next clock edge on. A difference in any single field sets nothing.
- R6: Equality that is present without `sec_tick_i` does not set the alarm status.
- R7: The alarm status stays set until a write with `wr_sel_i` 7 and `wr_data_i[0]` = 1. After that write it reads 0 from the next edge. The same write with bit 0 = 0 leaves it unchanged.
- R8: When a match and a clearing write happen in the same cycle, the status ends up set.
- R9: Outside power-off, `irq_alarm_o` and `wake_o` are high exactly while the alarm status and the alarm enable are both set. The status latches even while the enable is clear.
- R10: While `power_off_i` is high, `irq_timer_o` and `irq_alarm_o` are 0, and `wake_o` still follows the alarm status and the alarm enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-second update strobe |
| min_tick_i | input | 1 | One-minute update strobe |
| hour_tick_i | input | 1 | One-hour update strobe |
| day_tick_i | input | 1 | One-day update strobe |
| cur_time_i | input | 48 | Current BCD time: year, month, day, hour, minute, second (second in the low byte) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write target: 0-5 alarm fields, 6 control, 7 status clear |
| wr_data_i | input | 8 | Write data |
| power_off_i | input | 1 | Low-power state: core interrupts masked |
| irq_timer_o | output | 1 | Periodic interrupt |
| irq_alarm_o | output | 1 | Alarm interrupt to the core |
| wake_o | output | 1 | Alarm wake request, live in power-off |
| alarm_sts_o | output | 1 | Latched alarm status |

## Verification
The periodic path is driven with every rate code against every single strobe. This shows that each code selects its own strobe and no other. The alarm path is driven with times that differ from the alarm in one field at a time, and then with an exact match. This separates a full six-field compare from a partial one. The same exact time is also presented without the second strobe, which shows that only an update can set the status. A match is also made to coincide with a clearing write, to check which of the two wins. Finally, the enable and power-off inputs are swept while the status is held, which tells the core lines apart from the wake line.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned NUM_FIELDS = 6;
  localparam int unsigned TIME_W     = FIELD_W * NUM_FIELDS;
  localparam int unsigned SEL_W      = 3;

  typedef enum logic [1:0] {
    RATE_SEC  = 2'd0,
    RATE_MIN  = 2'd1,
    RATE_HOUR = 2'd2,
    RATE_DAY  = 2'd3
  } rate_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_DAY  = 3'd3,
    SEL_MON  = 3'd4,
    SEL_YEAR = 3'd5,
    SEL_CTRL = 3'd6,
    SEL_STAT = 3'd7
  } wr_sel_e;

  typedef struct packed {
    logic  alm_en;
    logic  per_en;
    rate_e rate;
  } ctrl_t;

  // day and month count from 1, the other fields from 0
  function automatic logic [FIELD_W-1:0] field_reset(input int unsigned idx);
    return (idx == 3 || idx == 4) ? FIELD_W'(1) : '0;
  endfunction
endpackage

// File: rtl/rtc_periodic_sel.sv
module rtc_periodic_sel
  import rtc_irq_pkg::*;
#(
  parameter int unsigned NUM_RATES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_RATES-1:0] tick_i,
  input  rate_e                rate_i,
  input  logic                 en_i,
  input  logic                 off_i,
  output logic                 irq_o
);
  logic [NUM_RATES-1:0] hit;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    assign hit[g] = tick_i[g] && (rate_i == rate_e'(g));
  end

  assign irq_o = en_i && !off_i && (|hit);

  assert_irq_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|tick_i));
endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_irq_pkg::*;
#(
  parameter int unsigned FW = FIELD_W,
  parameter int unsigned NF = NUM_FIELDS,
  parameter int unsigned SW = SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SW-1:0]    wr_sel_i,
  input  logic [FW-1:0]    wr_data_i,
  output logic [NF*FW-1:0] alarm_o
);
  for (genvar g = 0; g < NF; g++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        alarm_o[g*FW +: FW] <= field_reset(g);
      else if (wr_en_i && wr_sel_i == SW'(g))
        alarm_o[g*FW +: FW] <= wr_data_i;
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_irq_pkg::*;
#(
  parameter int unsigned FW = FIELD_W,
  parameter int unsigned NF = NUM_FIELDS
) (
  input  logic [NF*FW-1:0] cur_i,
  input  logic [NF*FW-1:0] alarm_i,
  input  logic             sec_tick_i,
  output logic             hit_o
);
  logic [NF-1:0] eq;

  for (genvar g = 0; g < NF; g++) begin : g_eq
    assign eq[g] = cur_i[g*FW +: FW] == alarm_i[g*FW +: FW];
  end

  // compare only on a second update so a match is seen once
  assign hit_o = sec_tick_i && (&eq);
endmodule

// File: rtl/rtc_alarm_status.sv
module rtc_alarm_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  output logic sts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sts_o <= 1'b0;
    else if (hit_i) sts_o <= 1'b1;  // set beats clear
    else if (clr_i) sts_o <= 1'b0;
  end

  assert_set_needs_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o) |-> $past(hit_i));
  assert_clear_needs_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sts_o) |-> $past(clr_i));
  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> sts_o);
endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen
  import rtc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_tick_i,
  input  logic              min_tick_i,
  input  logic              hour_tick_i,
  input  logic              day_tick_i,
  input  logic [TIME_W-1:0] cur_time_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [FIELD_W-1:0] wr_data_i,
  input  logic              power_off_i,
  output logic              irq_timer_o,
  output logic              irq_alarm_o,
  output logic              wake_o,
  output logic              alarm_sts_o
);
  ctrl_t             ctrl_q;
  logic [TIME_W-1:0] alarm_time;
  logic              hit;
  logic              clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      ctrl_q <= '0;
    else if (wr_en_i && wr_sel_i == SEL_CTRL)
      ctrl_q <= ctrl_t'(wr_data_i[3:0]);
  end

  assign clr = wr_en_i && (wr_sel_i == SEL_STAT) && wr_data_i[0];

  rtc_periodic_sel #(.NUM_RATES(4)) u_per (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i ({day_tick_i, hour_tick_i, min_tick_i, sec_tick_i}),
    .rate_i (ctrl_q.rate),
    .en_i   (ctrl_q.per_en),
    .off_i  (power_off_i),
    .irq_o  (irq_timer_o)
  );

  rtc_alarm_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .alarm_o   (alarm_time)
  );

  rtc_alarm_cmp u_cmp (
    .cur_i      (cur_time_i),
    .alarm_i    (alarm_time),
    .sec_tick_i (sec_tick_i),
    .hit_o      (hit)
  );

  rtc_alarm_status u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .clr_i  (clr),
    .sts_o  (alarm_sts_o)
  );

  assign wake_o      = alarm_sts_o && ctrl_q.alm_en;
  assign irq_alarm_o = wake_o && !power_off_i;

  assert_off_masks_core_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_off_i |-> (!irq_timer_o && !irq_alarm_o));
  assert_core_alarm_implies_wake_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_alarm_o |-> wake_o);
endmodule

// File: tb/rtc_irq_gen_test.sv
module rtc_irq_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sec_tick_i = 1'b0, min_tick_i = 1'b0, hour_tick_i = 1'b0, day_tick_i = 1'b0;
  logic [47:0] cur_time_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        power_off_i = 1'b0;
  logic        irq_timer_o, irq_alarm_o, wake_o, alarm_sts_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  // reference state built from the requirements
  logic [47:0] m_alarm = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
  logic [1:0]  m_rate  = 2'd0;
  logic        m_per   = 1'b0;
  logic        m_alm   = 1'b0;
  logic        m_sts   = 1'b0;

  always #10 clk_i = ~clk_i;

  rtc_irq_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sec_tick_i(sec_tick_i), .min_tick_i(min_tick_i),
    .hour_tick_i(hour_tick_i), .day_tick_i(day_tick_i),
    .cur_time_i(cur_time_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .power_off_i(power_off_i),
    .irq_timer_o(irq_timer_o), .irq_alarm_o(irq_alarm_o),
    .wake_o(wake_o), .alarm_sts_o(alarm_sts_o)
  );

  function automatic void check(logic [3:0] act, logic [3:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {timer,alarm,wake,sts} actual %b expected %b", tag, act, exp);
    end
  endfunction

  // driver: applies one cycle of stimulus, queues the expected outputs, advances the model
  task automatic cyc(input logic [3:0] ticks, input logic [47:0] t, input logic wr,
                     input logic [2:0] sel, input logic [7:0] d, input logic off,
                     input string tag);
    item_t it;
    logic  tsel, hit;
    @(negedge clk_i);
    {day_tick_i, hour_tick_i, min_tick_i, sec_tick_i} = ticks;
    cur_time_i = t; wr_en_i = wr; wr_sel_i = sel; wr_data_i = d; power_off_i = off;
    tsel = ticks[m_rate];
    it.exp = {m_per && tsel && !off, m_sts && m_alm && !off, m_sts && m_alm, m_sts};
    it.tag = tag;
    sb_q.push_back(it);
    hit = ticks[0] && (t == m_alarm);
    if (wr && sel < 3'd6) m_alarm[sel*8 +: 8] = d;
    if (wr && sel == 3'd6) begin m_rate = d[1:0]; m_per = d[2]; m_alm = d[3]; end
    if (hit) m_sts = 1'b1;
    else if (wr && sel == 3'd7 && d[0]) m_sts = 1'b0;
  endtask

  task automatic idle(input string tag);
    cyc(4'b0, 48'h0, 1'b0, 3'd0, 8'h0, 1'b0, tag);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d, input string tag);
    cyc(4'b0, 48'h0, 1'b1, sel, d, 1'b0, tag);
  endtask

  // monitor: compares queued expectations mid-cycle
  initial begin
    forever begin
      @(negedge clk_i);
      #5;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check({irq_timer_o, irq_alarm_o, wake_o, alarm_sts_o}, it.exp, it.tag);
      end
    end
  end

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] alm_t;
    alm_t = {8'h24, 8'h02, 8'h28, 8'h12, 8'h30, 8'h45};
    #15;
    check({irq_timer_o, irq_alarm_o, wake_o, alarm_sts_o}, 4'b0000, "R1 in reset");
    @(negedge clk_i); rst_ni = 1'b1;
    idle("R1 after reset");

    // R1: default alarm fields match 00-01-01 00:00:00 on a second strobe
    cyc(4'b0001, {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00}, 1'b0, 3'd0, 8'h0, 1'b0, "R1 default alarm");
    idle("R1 default alarm latched");
    wr(3'd7, 8'h01, "R7 clear");
    idle("R7 cleared");

    // R2: every rate against every strobe
    for (int r = 0; r < 4; r++) begin
      wr(3'd6, 8'(4 | r), "R2 set rate");
      for (int k = 0; k < 4; k++)
        cyc(4'(1 << k), 48'h0, 1'b0, 3'd0, 8'h0, 1'b0, "R2 rate select");
    end
    // R3: periodic enable clear
    wr(3'd6, 8'h00, "R3 disable");
    for (int k = 0; k < 4; k++)
      cyc(4'(1 << k), 48'h0, 1'b0, 3'd0, 8'h0, 1'b0, "R3 no periodic irq");

    // R4: load alarm fields, enable alarm
    for (int f = 0; f < 6; f++) wr(3'(f), alm_t[f*8 +: 8], "R4 alarm write");
    wr(3'd6, 8'h08, "R4 ctrl write");
    // R5: single-field mismatches
    for (int f = 0; f < 6; f++) begin
      logic [47:0] t;
      t = alm_t;
      t[f*8 +: 8] = t[f*8 +: 8] ^ 8'h01;
      cyc(4'b0001, t, 1'b0, 3'd0, 8'h0, 1'b0, "R5 field mismatch");
    end
    // R6: match without second strobe
    cyc(4'b1110, alm_t, 1'b0, 3'd0, 8'h0, 1'b0, "R6 no tick");
    idle("R6 not set");
    // R5: exact match
    cyc(4'b0001, alm_t, 1'b0, 3'd0, 8'h0, 1'b0, "R5 match");
    idle("R5 status and irq");
    // R7: bit 0 clear leaves status, bit 0 set clears
    wr(3'd7, 8'hFE, "R7 write zero bit");
    idle("R7 still set");
    wr(3'd7, 8'h01, "R7 clear");
    idle("R7 cleared");
    // R8: match and clear together
    cyc(4'b0001, alm_t, 1'b1, 3'd7, 8'h01, 1'b0, "R8 set vs clear");
    idle("R8 set wins");
    // R9: enable gates both outputs, status latched regardless
    wr(3'd6, 8'h00, "R9 alarm enable off");
    idle("R9 masked");
    wr(3'd6, 8'h0C, "R9 alarm enable on");
    idle("R9 unmasked");
    // R10: power-off masks core lines, wake stays
    cyc(4'b1111, 48'h0, 1'b0, 3'd0, 8'h0, 1'b1, "R10 off");
    cyc(4'b0001, 48'h0, 1'b0, 3'd0, 8'h0, 1'b0, "R10 on again");
    wr(3'd7, 8'h01, "R10 clear");
    cyc(4'b0000, 48'h0, 1'b0, 3'd0, 8'h0, 1'b1, "R10 off no wake");
    idle("R10 end");

    repeat (3) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule